// File: doc/BRIEF.md
# Serial Sampling Converter Port Model

This block is a synthesizable model of the digital face of a 12-bit serial sampling converter. A host drives an active-low frame select and a shift clock. The block answers on a serial data line that has an output enable, and it also tracks whether the modelled converter is powered up or asleep. The converted value arrives on a parallel input port and is captured when each frame opens.

Both host signals are asynchronous to the block. They pass through synchronisers clocked by a faster system clock, and edges are detected in that domain. A frame carries sixteen bit times: two zeros, the twelve-bit sample MSB first in straight binary, then two zeros. Where the host releases the frame select decides how the frame ends: the frame may complete, the conversion may be cut short, or the converter may enter sleep. A sleeping converter needs one complete dummy frame to wake, and the data in that frame is flagged invalid.

Top module: `adc_serial_port_emu`

## Requirements
- R1: While the synchronised frame select is high, `sdo_en` is low. Whenever `sdo_en` is low, `sdo` is 0.
- R2: A falling frame select sets `sdo_en` high and presents a 0 as bit time 0. In a powered-up converter it also raises `hold_active`.
- R3: Each falling shift-clock edge after that presents the next bit time k. Bit times 0 and 1 are 0, bit times 2..13 carry sample bits 11..0, and bit times 14 and 15 are 0. Rising shift-clock edges change nothing.
- R4: The sample is captured when the frame select falls. Changes on `sample_in` during the frame do not alter the bits shifted out.
- R5: In a powered-up frame, the 13th falling edge presents sample bit 0. `hold_active` stays high through the 13th falling edge and drops at the 14th.
- R6: The 16th falling edge sets `sdo_en` low. Further shift-clock edges with the frame select still low leave `sdo_en` low.
- R7: Raising the frame select after 2 to 9 falling edges (inclusive) in a powered-up frame sets `sdo_en` low and sets `asleep` to 1.
- R8: Raising the frame select after 10 to 15 falling edges sets `sdo_en` low and leaves `asleep` at 0.
- R9: After reset, `asleep` is 1, `hold_active` is 1 and `sdo_en` is 0.
- R10: A frame that opens while asleep is a dummy frame. `data_invalid` is 1 from its start until the next frame opens, and `hold_active` drops after its 1st falling edge. `asleep` clears at its 16th falling edge. If the frame select rises before that edge, the converter stays asleep.
- R11: Frames that open while powered up have `data_invalid` at 0. Raising the frame select after 0 or 1 falling edges does not change `asleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the shift clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_in | input | 1 | Frame select from the host, active low, asynchronous |
| sck_in | input | 1 | Shift clock from the host, asynchronous |
| sample_in | input | 12 | Converted value, straight binary |
| sdo | output | 1 | Serial data bit, 0 when not enabled |
| sdo_en | output | 1 | Output enable of the serial line (low = high impedance) |
| hold_active | output | 1 | 1 while the modelled sample/hold is in hold |
| asleep | output | 1 | 1 while the converter is in sleep |
| data_invalid | output | 1 | 1 for a frame whose data is wake-up data |

## Verification
Frame contents are tried with all-zeros and all-ones samples, alternating patterns, and single-bit patterns at each end of the word. These patterns show whether MSB-first ordering, the two leading and trailing zeros, and capture at frame start are correct. Release points are placed just below and at each boundary (1, 2, 9, 10, 14, 16 falling edges). This separates the no-change, sleep-entry and terminate windows. Dummy frames are run both to completion and cut short, which separates a wake from an aborted wake. A sample that changes mid-frame and shift-clock activity with the frame select high show that captured data and the disabled output are insulated from input changes.

// File: rtl/adcport_pkg.sv
package adcport_pkg;

   // edge events seen in the system clock domain
   typedef struct packed {
      logic cs_fall;
      logic cs_rise;
      logic sck_fall;
   } adcport_evt_t;

   // index of each host signal in the synchroniser vector
   localparam int unsigned IDX_CS  = 0;
   localparam int unsigned IDX_SCK = 1;

endpackage

// File: rtl/adcport_sync.sv
module adcport_sync #(
   parameter int unsigned   WIDTH   = 2,
   parameter int unsigned   STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] fall,
   output logic [WIDTH-1:0] rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("adcport_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= async_in;
   end

   generate
      for (genvar g = 1; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= stg[STAGES-1];
   end

   assign lvl  = stg[STAGES-1];
   assign fall = prev_q & ~lvl;
   assign rise = ~prev_q & lvl;

endmodule

// File: rtl/adcport_seq.sv
module adcport_seq #(
   parameter int unsigned FRAME_LEN   = 16,
   parameter int unsigned SAMPLE_EDGE = 14,
   parameter int unsigned SLEEP_LO    = 2,
   parameter int unsigned SLEEP_HI    = 10,
   parameter int unsigned CNT_W       = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  adcport_pkg::adcport_evt_t evt,
   output logic                      load_en,
   output logic                      shift_en,
   output logic                      oe,
   output logic                      asleep,
   output logic                      wake,
   output logic                      hold
);

   localparam logic [CNT_W-1:0] C_LAST   = CNT_W'(FRAME_LEN);
   localparam logic [CNT_W-1:0] C_SAMPLE = CNT_W'(SAMPLE_EDGE);
   localparam logic [CNT_W-1:0] C_SLO    = CNT_W'(SLEEP_LO);
   localparam logic [CNT_W-1:0] C_SHI    = CNT_W'(SLEEP_HI);
   localparam logic [CNT_W-1:0] C_ONE    = CNT_W'(1);

   logic             active_q;
   logic [CNT_W-1:0] fc_q;
   logic [CNT_W-1:0] fc_nxt;
   logic             in_sleep_win;

   assign fc_nxt       = fc_q + C_ONE;
   assign in_sleep_win = (fc_q >= C_SLO) && (fc_q < C_SHI);
   assign load_en      = evt.cs_fall;
   assign shift_en     = active_q && evt.sck_fall && !evt.cs_rise && !evt.cs_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         fc_q     <= '0;
         oe       <= 1'b0;
         asleep   <= 1'b1;
         wake     <= 1'b0;
      end else if (evt.cs_fall) begin
         active_q <= 1'b1;
         fc_q     <= '0;
         oe       <= 1'b1;
         wake     <= asleep;
      end else if (active_q && evt.cs_rise) begin
         active_q <= 1'b0;
         oe       <= 1'b0;
         if (!wake && in_sleep_win) asleep <= 1'b1;
      end else if (shift_en) begin
         fc_q <= fc_nxt;
         if (fc_nxt == C_LAST) begin
            active_q <= 1'b0;
            oe       <= 1'b0;
            if (wake) asleep <= 1'b0;
         end
      end
   end

   // hold: asleep keeps hold until the wake frame's first edge;
   // powered-up frames hold until the sample edge
   always_comb begin
      if (asleep) hold = !(active_q && wake && (fc_q >= C_ONE));
      else        hold = active_q && (fc_q < C_SAMPLE);
   end

endmodule

// File: rtl/adcport_shifter.sv
module adcport_shifter #(
   parameter int unsigned DATA_W    = 12,
   parameter int unsigned LEAD_Z    = 2,
   parameter int unsigned TRAIL_Z   = 2,
   parameter int unsigned FRAME_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              shift_en,
   input  logic [DATA_W-1:0] sample,
   output logic              bit_out
);

   generate
      if (FRAME_LEN != LEAD_Z + DATA_W + TRAIL_Z) begin : g_bad_len
         $error("adcport_shifter: FRAME_LEN mismatch");
      end
   endgenerate

   logic [FRAME_LEN-1:0] sreg_q;
   logic [FRAME_LEN-1:0] word;

   generate
      if (TRAIL_Z == 0) begin : g_no_trail
         assign word = {{LEAD_Z{1'b0}}, sample};
      end else begin : g_trail
         assign word = {{LEAD_Z{1'b0}}, sample, {TRAIL_Z{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sreg_q <= '0;
      else if (load_en)  sreg_q <= word;
      else if (shift_en) sreg_q <= {sreg_q[FRAME_LEN-2:0], 1'b0};
   end

   assign bit_out = sreg_q[FRAME_LEN-1];

endmodule

// File: rtl/adc_serial_port_emu.sv
module adc_serial_port_emu #(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned LEAD_Z      = 2,
   parameter int unsigned TRAIL_Z     = 2,
   parameter int unsigned SLEEP_LO    = 2,
   parameter int unsigned SLEEP_HI    = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_in,
   input  logic              sck_in,
   input  logic [DATA_W-1:0] sample_in,
   output logic              sdo,
   output logic              sdo_en,
   output logic              hold_active,
   output logic              asleep,
   output logic              data_invalid
);
   import adcport_pkg::*;

   localparam int unsigned FRAME_LEN   = LEAD_Z + DATA_W + TRAIL_Z;
   localparam int unsigned SAMPLE_EDGE = LEAD_Z + DATA_W;
   localparam int unsigned CNT_W       = $clog2(FRAME_LEN + 1);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("adc_serial_port_emu: DATA_W too small");
      end
      if (!(SLEEP_LO < SLEEP_HI && SLEEP_HI <= FRAME_LEN)) begin : g_bad_win
         $error("adc_serial_port_emu: sleep window out of frame");
      end
   endgenerate

   logic [1:0]   async_v;
   logic [1:0]   lvl_v;
   logic [1:0]   fall_v;
   logic [1:0]   rise_v;
   adcport_evt_t evt;
   logic         load_en;
   logic         shift_en;
   logic         oe;
   logic         bit_out;

   assign async_v[IDX_CS]  = cs_n_in;
   assign async_v[IDX_SCK] = sck_in;

   adcport_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b01)
   ) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (async_v),
      .lvl      (lvl_v),
      .fall     (fall_v),
      .rise     (rise_v)
   );

   assign evt.cs_fall  = fall_v[IDX_CS];
   assign evt.cs_rise  = rise_v[IDX_CS];
   assign evt.sck_fall = fall_v[IDX_SCK];

   adcport_seq #(
      .FRAME_LEN   (FRAME_LEN),
      .SAMPLE_EDGE (SAMPLE_EDGE),
      .SLEEP_LO    (SLEEP_LO),
      .SLEEP_HI    (SLEEP_HI),
      .CNT_W       (CNT_W)
   ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .load_en  (load_en),
      .shift_en (shift_en),
      .oe       (oe),
      .asleep   (asleep),
      .wake     (data_invalid),
      .hold     (hold_active)
   );

   adcport_shifter #(
      .DATA_W    (DATA_W),
      .LEAD_Z    (LEAD_Z),
      .TRAIL_Z   (TRAIL_Z),
      .FRAME_LEN (FRAME_LEN)
   ) shift_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .shift_en (shift_en),
      .sample   (sample_in),
      .bit_out  (bit_out)
   );

   assign sdo_en = oe;
   assign sdo    = oe & bit_out;

endmodule

// File: rtl/adcport_chk.sv
module adcport_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] lvl_v,
   input logic [1:0] rise_v,
   input logic [1:0] fall_v,
   input logic       sdo,
   input logic       sdo_en,
   input logic       hold_active,
   input logic       asleep
);
   import adcport_pkg::*;

   AST_EN_OFF_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_v[IDX_CS] && $past(lvl_v[IDX_CS]) |-> !sdo_en);  // R1

   AST_SDO_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_en |-> !sdo);  // R1

   AST_FIRST_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_en) |-> !sdo);  // R2

   AST_SCK_RISE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      rise_v[IDX_SCK] && !fall_v[IDX_CS] && !rise_v[IDX_CS]
      |=> $stable(sdo) && $stable(sdo_en));  // R3

   AST_SHIFT_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_en && $past(sdo_en) && !$stable(sdo) |-> !lvl_v[IDX_SCK]);  // R3

   AST_SLEEP_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep) |-> $fell(sdo_en));  // R7

   AST_WAKE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asleep) |-> $fell(sdo_en));  // R10

   AST_HOLD_WHILE_IDLE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      asleep && !sdo_en |-> hold_active);  // R10

endmodule

bind adc_serial_port_emu adcport_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .lvl_v       (lvl_v),
   .rise_v      (rise_v),
   .fall_v      (fall_v),
   .sdo         (sdo),
   .sdo_en      (sdo_en),
   .hold_active (hold_active),
   .asleep      (asleep)
);

// File: tb/adc_serial_port_emu_tb_top.sv
module adc_serial_port_emu_tb_top;

   localparam int NVEC = 13;
   localparam int SETTLE = 4;

   // entry: [18:7] sample, [6:2] falls before release, [1] dummy frame, [0] asleep after
   localparam logic [18:0] VEC [NVEC] = '{
      {12'hA5C, 5'd16, 1'b1, 1'b0},   // R10 wake frame
      {12'hFFF, 5'd16, 1'b0, 1'b0},   // R3 all ones
      {12'h000, 5'd16, 1'b0, 1'b0},   // R3 all zeros
      {12'h801, 5'd14, 1'b0, 1'b0},   // R8 release at 14
      {12'h123, 5'd10, 1'b0, 1'b0},   // R8 boundary 10
      {12'h3C7, 5'd9,  1'b0, 1'b1},   // R7 boundary 9
      {12'h555, 5'd16, 1'b1, 1'b0},   // R10 wake
      {12'h0F0, 5'd2,  1'b0, 1'b1},   // R7 boundary 2
      {12'hAAA, 5'd5,  1'b1, 1'b1},   // R10 aborted wake
      {12'h001, 5'd16, 1'b1, 1'b0},   // R10 wake
      {12'h6D9, 5'd1,  1'b0, 1'b0},   // R11 release at 1
      {12'hFFE, 5'd0,  1'b0, 1'b0},   // R11 release at 0
      {12'h7FF, 5'd16, 1'b0, 1'b0}    // R3 R6
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n_in = 1'b1;
   logic        sck_in = 1'b0;
   logic [11:0] sample_in = '0;
   logic        sdo, sdo_en, hold_active, asleep, data_invalid;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   adc_serial_port_emu dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_n_in      (cs_n_in),
      .sck_in       (sck_in),
      .sample_in    (sample_in),
      .sdo          (sdo),
      .sdo_en       (sdo_en),
      .hold_active  (hold_active),
      .asleep       (asleep),
      .data_invalid (data_invalid)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic sck_pulse();
      @(negedge clk) sck_in = 1'b1;
      settle();
      sck_in = 1'b0;
      settle();
   endtask

   task automatic cs_drive(input logic v);
      @(negedge clk) cs_n_in = v;
      settle();
   endtask

   initial begin
      #(150000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] word;
      logic [11:0] smp;
      int          nf;
      logic        dummy, exp_sleep;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      chk("R9 asleep", asleep, 1);
      chk("R9 hold", hold_active, 1);
      chk("R9 sdo_en", sdo_en, 0);
      chk("R1 sdo idle", sdo, 0);

      // R1: shift clock activity with frame select high
      sck_pulse();
      sck_pulse();
      chk("R1 en stays off", sdo_en, 0);
      chk("R1 asleep unchanged", asleep, 1);

      for (int v = 0; v < NVEC; v++) begin
         smp       = VEC[v][18:7];
         nf        = int'(VEC[v][6:2]);
         dummy     = VEC[v][1];
         exp_sleep = VEC[v][0];
         word      = {2'b00, smp, 2'b00};
         sample_in = smp;
         cs_drive(1'b0);
         sample_in = ~smp;   // R4: later changes must not show
         chk(dummy ? "R10 invalid flag" : "R11 invalid flag", data_invalid, int'(dummy));
         chk("R2 en at start", sdo_en, 1);
         chk("R2 first zero", sdo, 0);
         chk("R2 hold at start", hold_active, 1);
         for (int k = 1; k <= nf; k++) begin
            sck_pulse();
            if (k < 16) begin
               chk("R3 R4 en", sdo_en, 1);
               chk((k == 13) ? "R5 lsb bit" : "R3 R4 bit", sdo, int'(word[15-k]));
               if (dummy) chk("R10 hold", hold_active, (k < 1) ? 1 : 0);
               else       chk("R5 hold", hold_active, (k < 14) ? 1 : 0);
            end else begin
               chk("R6 en off at 16", sdo_en, 0);
               chk(dummy ? "R10 awake at 16" : "R6 awake", asleep, 0);
               sck_pulse();
               chk("R6 extra edge", sdo_en, 0);
            end
         end
         cs_drive(1'b1);
         chk("R7 R8 en off", sdo_en, 0);
         chk((nf >= 2 && nf < 10) ? "R7 asleep" :
             (nf < 2) ? "R11 asleep" : "R8 asleep", asleep, int'(exp_sleep));
         chk("R10 hold after", hold_active, int'(exp_sleep));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule